// File: doc/BRIEF.md
# SDRAM Bank State Monitor

This block watches the command bus of a four-bank DDR SDRAM from the controller side. It samples the command lines, the clock-enable, the bank select and the address on every rising clock edge. From these it keeps a copy of which banks have a row open and which row each one holds. It flags commands that the memory would not accept in its current state. It does not touch the data path. It is meant to sit beside a memory controller in simulation or in silicon as a protocol guard.

Read and write bursts are timed from a burst-length setting. A read or write that asks for auto-precharge closes its bank by itself when the burst ends, with no further command. A precharge closes either one bank or all banks, depending on one address bit. Each class of violation sets its own sticky flag. The code of the first violation is also held until reset.

Top module: `sdram_bank_monitor`

## Requirements
- R1: While `rst_n` is low at a rising edge, all banks read idle, `bank_row` is zero, `err_vec` is zero and `err_code` is 0.
- R2: Commands are decoded at the rising edge from {`cmd_sel_n`,`cmd_row_n`,`cmd_col_n`,`cmd_wr_n`]: `cmd_sel_n` high is a deselect (no operation); 0111 no operation, 0011 activate, 0101 read, 0100 write, 0010 precharge, 0001 refresh, 0000 mode-register load, 0110 burst stop (no effect). An activate to an idle bank sets `bank_open[bank_sel]` and stores `addr_in` as that bank's row in `bank_row[14*b +: 14]`. The new state is visible right after that edge. A bank's row field is meaningful only while the bank is open.
- R3: A precharge with `addr_in[10]` = 0 closes only the bank named by `bank_sel`, and leaves every other bank unchanged.
- R4: A precharge with `addr_in[10]` = 1 closes every bank, whatever the value of `bank_sel`.
- R5: `burst_code` 1, 2 and 3 select burst lengths of 2, 4 and 8; any other code acts as 1. A read or write to an open bank with `addr_in[10]` = 1 closes that bank at the (length/2)-th rising edge after the command edge. With `addr_in[10]` = 0 the bank stays open.
- R6: An activate to a bank that is already open sets error code 1 and leaves that bank's row unchanged.
- R7: A read or write to an idle bank sets error code 2 and starts no burst.
- R8: A mode-register load (any `bank_sel`) sets error code 3 if any bank is open, or if it comes within length/2 edges after a legal read or write.
- R9: With `clk_en` low at the edge, any command other than deselect, no operation or refresh (self-refresh entry) sets error code 4 and has no effect on bank state.
- R10: Error code k (1 to 4) sets `err_vec[k-1]`. These bits only clear on reset. `err_code` holds the code of the first error after reset until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all sampling on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_sel_n | input | 1 | Chip-select line of the command, active low |
| cmd_row_n | input | 1 | Row-strobe line of the command, active low |
| cmd_col_n | input | 1 | Column-strobe line of the command, active low |
| cmd_wr_n | input | 1 | Write-enable line of the command, active low |
| clk_en | input | 1 | Clock-enable line of the memory |
| bank_sel | input | 2 | Bank address |
| addr_in | input | 14 | Row or column address; bit 10 selects precharge scope or auto-precharge |
| burst_code | input | 3 | Burst-length setting (1:2, 2:4, 3:8) |
| bank_open | output | 4 | One bit per bank, high while a row is open |
| bank_row | output | 56 | Stored row per bank, 14 bits each, bank 0 in the low bits |
| err_vec | output | 4 | Sticky flag per error code |
| err_code | output | 3 | Code of the first error since reset |

## Verification
On every cycle, the assertions check these rules: an activate loads its row, a single-bank or all-bank precharge closes its targets, an auto-precharge counter running out closes its bank, a legal burst makes the block busy, and the gated commands under low clock-enable open nothing. They also check that error flags and the first code never change once set. Only the bench's scenarios can show the exact closing edge for each burst length, the default treatment of unknown burst codes, and that bank rows survive rejected commands. The same holds for the one-edge boundary where a mode load becomes legal again, and for a precharge that ends a bank while a burst is still timed.

// File: rtl/sbm_pkg.sv
// Shared types for the SDRAM bank state monitor.
// Assumes a four-line command code and a three-bit burst-length setting.
package sbm_pkg;

    typedef enum logic [2:0] {
        CMD_NOP  = 3'd0,
        CMD_ACT  = 3'd1,
        CMD_RD   = 3'd2,
        CMD_WR   = 3'd3,
        CMD_PRE  = 3'd4,
        CMD_REF  = 3'd5,
        CMD_MODE = 3'd6,
        CMD_STOP = 3'd7
    } cmd_e;

    typedef enum logic [2:0] {
        ERR_NONE      = 3'd0,
        ERR_ACT_OPEN  = 3'd1,
        ERR_RW_IDLE   = 3'd2,
        ERR_MODE_BUSY = 3'd3,
        ERR_CLK_OFF   = 3'd4
    } err_e;

    localparam int NUM_ERR = 4;
    localparam int HALF_W  = 3;

    // Clock cycles taken by one burst: two transfers per clock.
    function automatic logic [HALF_W-1:0] half_burst(input logic [2:0] code);
        case (code)
            3'd2:    return 3'd2;
            3'd3:    return 3'd4;
            default: return 3'd1;
        endcase
    endfunction

endpackage

// File: rtl/sbm_cmd_decode.sv
// Command decoder: maps the four active-low command lines to a command type.
// Assumes the lines are already stable at the sampling edge.
module sbm_cmd_decode
    import sbm_pkg::*;
(
    input  logic sel_n,
    input  logic row_n,
    input  logic col_n,
    input  logic wr_n,
    output cmd_e cmd
);

    // Decode the strobe pattern; a deselected chip is a no-operation.
    always_comb begin
        if (sel_n) begin
            cmd = CMD_NOP;
        end else begin
            case ({row_n, col_n, wr_n})
                3'b011:  cmd = CMD_ACT;
                3'b101:  cmd = CMD_RD;
                3'b100:  cmd = CMD_WR;
                3'b010:  cmd = CMD_PRE;
                3'b001:  cmd = CMD_REF;
                3'b000:  cmd = CMD_MODE;
                3'b110:  cmd = CMD_STOP;
                default: cmd = CMD_NOP;
            endcase
        end
    end

endmodule

// File: rtl/sbm_bank_slice.sv
// One bank's state: open flag, stored row and auto-precharge countdown.
// Assumes the hit inputs are already qualified (legal, clock enabled, this bank).
module sbm_bank_slice #(
    parameter int ROW_W  = 14,
    parameter int HALF_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              act_hit,
    input  logic              rw_hit,
    input  logic              rw_autopre,
    input  logic              pre_hit,
    input  logic [ROW_W-1:0]  row_in,
    input  logic [HALF_W-1:0] half_len,
    output logic              is_open,
    output logic [ROW_W-1:0]  row_q
);

    logic [HALF_W-1:0] left_q;

    // Bank state update: precharge beats activate beats burst beats countdown.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            is_open <= 1'b0;
            row_q   <= '0;
            left_q  <= '0;
        end else if (pre_hit) begin
            is_open <= 1'b0;
            left_q  <= '0;
        end else if (act_hit) begin
            is_open <= 1'b1;
            row_q   <= row_in;
            left_q  <= '0;
        end else if (rw_hit) begin
            left_q  <= rw_autopre ? half_len : '0;
        end else if (left_q != '0) begin
            left_q  <= left_q - 1'b1;
            if (left_q == HALF_W'(1)) begin
                is_open <= 1'b0;
            end
        end
    end

    // R2: an accepted activate opens the bank with the sampled row.
    p_act_row_r2: assert property (@(posedge clk) disable iff (!rst_n)
        act_hit |=> (is_open && row_q == $past(row_in)));

    // R3: a precharge aimed at this bank closes it.
    p_pre_close_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pre_hit |=> !is_open);

    // R5: the last countdown step closes the bank when nothing else intervenes.
    p_ap_close_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (left_q == HALF_W'(1) && !pre_hit && !act_hit && !rw_hit) |=> !is_open);

endmodule

// File: rtl/sbm_burst_timer.sv
// Tracks whether a read or write burst is still on the bus.
// Assumes start pulses only for legal bursts; a new burst restarts the count.
module sbm_burst_timer #(
    parameter int HALF_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [HALF_W-1:0] half_len,
    output logic              busy
);

    logic [HALF_W-1:0] cnt_q;

    // Load on a new burst, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= half_len;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign busy = (cnt_q != '0);

    // R8: a legal burst keeps the bus busy on the next edge.
    p_start_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);

    // R8: the busy window ends once the count runs out.
    p_busy_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && cnt_q == HALF_W'(1)) |=> !busy);

endmodule

// File: rtl/sbm_err_track.sv
// Sticky error record: one flag per code plus the first code seen.
// Assumes at most one error event per cycle.
module sbm_err_track
    import sbm_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  err_e               evt,
    output logic [NUM_ERR-1:0] err_vec,
    output logic [2:0]         err_code
);

    logic [NUM_ERR-1:0] set_mask;
    err_e               code_q;

    // Turn the event code into the flag it sets.
    always_comb begin
        set_mask = '0;
        case (evt)
            ERR_ACT_OPEN:  set_mask[0] = 1'b1;
            ERR_RW_IDLE:   set_mask[1] = 1'b1;
            ERR_MODE_BUSY: set_mask[2] = 1'b1;
            ERR_CLK_OFF:   set_mask[3] = 1'b1;
            default:       set_mask    = '0;
        endcase
    end

    // Accumulate flags and latch the first code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_vec <= '0;
            code_q  <= ERR_NONE;
        end else begin
            err_vec <= err_vec | set_mask;
            if (code_q == ERR_NONE && evt != ERR_NONE) begin
                code_q <= evt;
            end
        end
    end

    assign err_code = code_q;

    // R10: a raised flag never drops before reset.
    p_vec_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (|err_vec) |=> ((err_vec & $past(err_vec)) == $past(err_vec)));

    // R10: the first code is held.
    p_code_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (code_q != ERR_NONE) |=> $stable(code_q));

    // R10: the first event after reset is the one recorded.
    p_first_code_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (code_q == ERR_NONE && evt != ERR_NONE) |=> (code_q == $past(evt)));

endmodule

// File: rtl/sdram_bank_monitor.sv
// SDRAM bank state monitor: follows bank open/idle state from the command bus
// and flags commands that are illegal in that state.
// Assumes one command per clock, sampled on the rising edge.
module sdram_bank_monitor
    import sbm_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int ADDR_W    = 14,
    parameter int AP_BIT    = 10
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cmd_sel_n,
    input  logic                        cmd_row_n,
    input  logic                        cmd_col_n,
    input  logic                        cmd_wr_n,
    input  logic                        clk_en,
    input  logic [$clog2(NUM_BANKS)-1:0] bank_sel,
    input  logic [ADDR_W-1:0]           addr_in,
    input  logic [2:0]                  burst_code,
    output logic [NUM_BANKS-1:0]        bank_open,
    output logic [NUM_BANKS*ADDR_W-1:0] bank_row,
    output logic [NUM_ERR-1:0]          err_vec,
    output logic [2:0]                  err_code
);

    localparam int BA_W = $clog2(NUM_BANKS);

    cmd_e              cmd;
    err_e              evt;
    logic              gated_bad;
    logic              sel_open;
    logic              is_rw;
    logic              burst_busy;
    logic              burst_start;
    logic [HALF_W-1:0] half_len;
    logic [NUM_BANKS-1:0] open_q;

    sbm_cmd_decode u_decode (
        .sel_n (cmd_sel_n),
        .row_n (cmd_row_n),
        .col_n (cmd_col_n),
        .wr_n  (cmd_wr_n),
        .cmd   (cmd)
    );

    assign half_len  = half_burst(burst_code);
    assign sel_open  = open_q[bank_sel];
    assign is_rw     = (cmd == CMD_RD) || (cmd == CMD_WR);
    // Only deselect/no-op and refresh (self-refresh entry) are allowed with the clock gated.
    assign gated_bad = !clk_en && (cmd != CMD_NOP) && (cmd != CMD_REF);
    assign burst_start = !gated_bad && is_rw && sel_open;

    // Classify the sampled command against the current bank state.
    always_comb begin
        evt = ERR_NONE;
        if (gated_bad) begin
            evt = ERR_CLK_OFF;
        end else begin
            case (cmd)
                CMD_ACT:  if (sel_open) evt = ERR_ACT_OPEN;
                CMD_RD,
                CMD_WR:   if (!sel_open) evt = ERR_RW_IDLE;
                CMD_MODE: if ((|open_q) || burst_busy) evt = ERR_MODE_BUSY;
                default:  evt = ERR_NONE;
            endcase
        end
    end

    sbm_burst_timer #(.HALF_W(HALF_W)) u_burst (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (burst_start),
        .half_len (half_len),
        .busy     (burst_busy)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic here;
        assign here = (bank_sel == BA_W'(b));

        sbm_bank_slice #(.ROW_W(ADDR_W), .HALF_W(HALF_W)) u_slice (
            .clk        (clk),
            .rst_n      (rst_n),
            .act_hit    (!gated_bad && cmd == CMD_ACT && here && !sel_open),
            .rw_hit     (burst_start && here),
            .rw_autopre (addr_in[AP_BIT]),
            .pre_hit    (!gated_bad && cmd == CMD_PRE && (addr_in[AP_BIT] || here)),
            .row_in     (addr_in),
            .half_len   (half_len),
            .is_open    (open_q[b]),
            .row_q      (bank_row[b*ADDR_W +: ADDR_W])
        );
    end

    sbm_err_track u_err (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (evt),
        .err_vec  (err_vec),
        .err_code (err_code)
    );

    assign bank_open = open_q;

    // R4: an all-bank precharge leaves no bank open.
    p_pre_all_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && cmd == CMD_PRE && addr_in[AP_BIT]) |=> (bank_open == '0));

    // R9: a rejected gated command opens no bank.
    p_gated_no_open_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en && cmd != CMD_NOP && cmd != CMD_REF)
            |=> ((bank_open & ~$past(bank_open)) == '0));

    // R7: a column access to an idle bank raises its flag.
    p_rw_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && is_rw && !sel_open) |=> err_vec[1]);

    // R8: a mode load with a bank open raises its flag.
    p_mode_open_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && cmd == CMD_MODE && (|bank_open)) |=> err_vec[2]);

    // R6: activating an open bank raises its flag.
    p_act_open_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && cmd == CMD_ACT && sel_open) |=> err_vec[0]);

endmodule

// File: tb/sdram_bank_monitor_test.sv
// Scoreboard bench: the driver task steps a reference model and queues the
// expected state; the monitor pops one item after each rising edge.
module sdram_bank_monitor_test;
    import sbm_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_sel_n = 1'b1, cmd_row_n = 1'b1, cmd_col_n = 1'b1, cmd_wr_n = 1'b1;
    logic        clk_en = 1'b1;
    logic [1:0]  bank_sel = '0;
    logic [13:0] addr_in = '0;
    logic [2:0]  burst_code = 3'd1;
    logic [3:0]  bank_open;
    logic [55:0] bank_row;
    logic [3:0]  err_vec;
    logic [2:0]  err_code;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        string       req;
        logic [3:0]  open;
        logic [13:0] rows [4];
        logic [3:0]  vec;
        logic [2:0]  code;
    } exp_t;

    exp_t sb_q[$];

    // Reference model state
    int          cyc = 0;
    int          busy_until = 0;
    logic [3:0]  m_open = '0;
    logic [13:0] m_row [4];
    int          m_close_at [4];
    logic [3:0]  m_vec = '0;
    logic [2:0]  m_code = '0;

    sdram_bank_monitor uut (
        .clk(clk), .rst_n(rst_n),
        .cmd_sel_n(cmd_sel_n), .cmd_row_n(cmd_row_n),
        .cmd_col_n(cmd_col_n), .cmd_wr_n(cmd_wr_n),
        .clk_en(clk_en), .bank_sel(bank_sel), .addr_in(addr_in),
        .burst_code(burst_code),
        .bank_open(bank_open), .bank_row(bank_row),
        .err_vec(err_vec), .err_code(err_code)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Command line pattern per R2: {sel_n,row_n,col_n,wr_n}
    function automatic logic [3:0] enc(input cmd_e c);
        case (c)
            CMD_ACT:  return 4'b0011;
            CMD_RD:   return 4'b0101;
            CMD_WR:   return 4'b0100;
            CMD_PRE:  return 4'b0010;
            CMD_REF:  return 4'b0001;
            CMD_MODE: return 4'b0000;
            CMD_STOP: return 4'b0110;
            default:  return 4'b0111;
        endcase
    endfunction

    task automatic model_reset();
        cyc = 0; busy_until = 0; m_open = '0; m_vec = '0; m_code = '0;
        for (int b = 0; b < 4; b++) begin m_row[b] = '0; m_close_at[b] = 0; end
    endtask

    // Drive one command and push the state expected after the next edge.
    task automatic issue(input string req, input cmd_e c, input logic ke,
                         input logic [1:0] ba, input logic [13:0] a,
                         input logic [2:0] bc);
        int n, hl, e;
        logic bad, so, rw;
        exp_t it;
        @(negedge clk);
        {cmd_sel_n, cmd_row_n, cmd_col_n, cmd_wr_n} = enc(c);
        clk_en = ke; bank_sel = ba; addr_in = a; burst_code = bc;
        cyc++; n = cyc;
        hl  = (bc == 3'd2) ? 2 : (bc == 3'd3) ? 4 : 1;
        bad = !ke && !(c == CMD_NOP || c == CMD_REF);
        so  = m_open[ba];
        rw  = (c == CMD_RD) || (c == CMD_WR);
        e = 0;
        if (bad) e = 4;
        else if (c == CMD_ACT && so) e = 1;
        else if (rw && !so) e = 2;
        else if (c == CMD_MODE && ((|m_open) || n <= busy_until)) e = 3;
        if (!bad && rw && so) busy_until = n + hl;
        for (int b = 0; b < 4; b++) begin
            if (!bad && c == CMD_PRE && (a[10] || ba == 2'(b))) begin
                m_open[b] = 1'b0; m_close_at[b] = 0;
            end else if (!bad && c == CMD_ACT && !so && ba == 2'(b)) begin
                m_open[b] = 1'b1; m_row[b] = a; m_close_at[b] = 0;
            end else if (!bad && rw && so && ba == 2'(b)) begin
                m_close_at[b] = a[10] ? n + hl : 0;
            end else if (m_close_at[b] != 0 && m_close_at[b] == n) begin
                m_open[b] = 1'b0; m_close_at[b] = 0;
            end
        end
        if (e != 0) begin
            m_vec[e-1] = 1'b1;
            if (m_code == 0) m_code = 3'(e);
        end
        it.req = req; it.open = m_open; it.vec = m_vec; it.code = m_code;
        for (int b = 0; b < 4; b++) it.rows[b] = m_row[b];
        sb_q.push_back(it);
    endtask

    task automatic idle(input string req, input int count);
        for (int i = 0; i < count; i++) issue(req, CMD_NOP, 1'b1, 2'd0, 14'h0, 3'd1);
    endtask

    // Monitor: compare one queued expectation just after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                exp_t it;
                it = sb_q.pop_front();
                chk(it.req, "bank_open", 64'(bank_open), 64'(it.open));
                chk({it.req, "/R10"}, "err_vec", 64'(err_vec), 64'(it.vec));
                chk({it.req, "/R10"}, "err_code", 64'(err_code), 64'(it.code));
                for (int b = 0; b < 4; b++)
                    if (it.open[b])
                        chk(it.req, $sformatf("row%0d", b),
                            64'(bank_row[b*14 +: 14]), 64'(it.rows[b]));
            end
        end
    end

    // Watchdog
    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        #1;
        chk("R1", "bank_open", 64'(bank_open), 64'h0);
        chk("R1", "bank_row", 64'(bank_row), 64'h0);
        chk("R1", "err_vec", 64'(err_vec), 64'h0);
        chk("R1", "err_code", 64'(err_code), 64'h0);
        @(negedge clk) rst_n = 1'b1;

        // R2: open two banks
        issue("R2", CMD_ACT, 1'b1, 2'd0, 14'h1234, 3'd1);
        issue("R2", CMD_ACT, 1'b1, 2'd2, 14'h0abc, 3'd1);
        // R6: activate an open bank, row must survive
        issue("R6", CMD_ACT, 1'b1, 2'd0, 14'h0555, 3'd1);
        // R3: single-bank precharge
        issue("R3", CMD_PRE, 1'b1, 2'd0, 14'h0000, 3'd1);
        // R7: read of an idle bank
        issue("R7", CMD_RD, 1'b1, 2'd0, 14'h0010, 3'd1);
        // R4: all-bank precharge with an unrelated bank address
        issue("R2", CMD_ACT, 1'b1, 2'd1, 14'h3fff, 3'd1);
        issue("R2", CMD_ACT, 1'b1, 2'd3, 14'h0001, 3'd1);
        issue("R4", CMD_PRE, 1'b1, 2'd2, 14'h0400, 3'd1);
        // R5: write with auto-precharge, length 8 closes after 4 edges
        issue("R5", CMD_ACT, 1'b1, 2'd1, 14'h0022, 3'd1);
        issue("R5", CMD_WR, 1'b1, 2'd1, 14'h0408, 3'd3);
        idle("R5", 5);
        // R5: read without auto-precharge keeps the bank open
        issue("R5", CMD_ACT, 1'b1, 2'd3, 14'h2a2a, 3'd1);
        issue("R5", CMD_RD, 1'b1, 2'd3, 14'h0004, 3'd2);
        idle("R5", 3);
        issue("R3", CMD_PRE, 1'b1, 2'd3, 14'h0000, 3'd1);
        // R5: unknown burst code acts as length 2
        issue("R5", CMD_ACT, 1'b1, 2'd2, 14'h0100, 3'd1);
        issue("R5", CMD_RD, 1'b1, 2'd2, 14'h0400, 3'd0);
        idle("R5", 2);
        // R8: mode load legal right after an auto-precharge burst ends
        issue("R8", CMD_ACT, 1'b1, 2'd0, 14'h0077, 3'd1);
        issue("R8", CMD_RD, 1'b1, 2'd0, 14'h0400, 3'd2);
        idle("R8", 2);
        issue("R8", CMD_MODE, 1'b1, 2'd0, 14'h0032, 3'd1);
        issue("R8", CMD_MODE, 1'b1, 2'd1, 14'h0000, 3'd1);
        // R8: mode load with all banks idle but a burst still timed
        issue("R8", CMD_ACT, 1'b1, 2'd1, 14'h0333, 3'd1);
        issue("R8", CMD_RD, 1'b1, 2'd1, 14'h0000, 3'd3);
        issue("R8", CMD_PRE, 1'b1, 2'd1, 14'h0000, 3'd1);
        issue("R8", CMD_MODE, 1'b1, 2'd0, 14'h0032, 3'd1);
        idle("R8", 4);
        // R9: self-refresh entry and no-op are allowed with clk_en low
        issue("R9", CMD_REF, 1'b0, 2'd0, 14'h0000, 3'd1);
        issue("R9", CMD_NOP, 1'b0, 2'd0, 14'h0000, 3'd1);
        issue("R9", CMD_NOP, 1'b1, 2'd0, 14'h0000, 3'd1);
        // R9: gated activate is rejected and opens nothing
        issue("R9", CMD_ACT, 1'b0, 2'd0, 14'h1111, 3'd1);
        // R9: gated all-bank precharge leaves an open bank open
        issue("R9", CMD_ACT, 1'b1, 2'd2, 14'h0f0f, 3'd1);
        issue("R9", CMD_PRE, 1'b0, 2'd0, 14'h0400, 3'd1);
        idle("R9", 2);

        wait (sb_q.size() == 0);
        repeat (2) @(posedge clk);

        // R1: reset clears everything again
        @(negedge clk) rst_n = 1'b0;
        @(posedge clk);
        #1;
        chk("R1", "bank_open", 64'(bank_open), 64'h0);
        chk("R1", "err_vec", 64'(err_vec), 64'h0);
        chk("R1", "err_code", 64'(err_code), 64'h0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule